// File: doc/BRIEF.md
# Paged Address Translator with Access-Type Checks

This block turns a virtual address into a physical address using fixed-size pages. The low bits of the address are the offset inside a page. The bits above them are the page number. The page number selects an entry in a small on-chip page table. Each entry holds a frame number and three attribute bits: present, writable and no-execute. Every request also states what kind of access it is. The block compares that kind against the page attributes. It returns either the physical address or a code that says which protection rule was broken.

Software, or a neighbouring controller, fills the table through a load port. A load writes one entry in a single cycle. Requests enter on a valid/ready handshake. Results leave one cycle later through a registered response with its own valid/ready handshake. The response is held while the consumer stalls. The page size is a build parameter. It must be a power of two between 512 and 8192 bytes. The table depth and the address widths are parameters as well.

Top module: `pgxl_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every table entry is not present. The first request to any page therefore returns the invalid fault.
- R2: On a translation without a fault, `rsp_pa` equals the entry's frame number in the upper bits, concatenated with the request offset. The offset bits pass through unchanged.
- R3: A read, or any access with no rule broken, on a present entry returns fault code 00.
- R4: If the entry is not present, or the page number is at or beyond the table depth, the result is fault code 01 with `rsp_pa` equal to 0. Every faulting response drives `rsp_pa` to 0.
- R5: A write, kind 01, to an entry whose writable bit is 0 returns fault code 10.
- R6: A fetch, kind 10, from an entry whose no-execute bit is 1 returns fault code 11. A read, or a write to a writable page, on a no-execute page does not fault.
- R7: When the page is invalid and another fault would also apply, the invalid fault 01 is reported.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` = 1 at the next edge.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_pa` and `rsp_fault` stay unchanged.
- R10: If a table load and an accepted request happen at the same edge, the request sees the entry as it was before the load. Later requests see the new entry.
- R11: Access kind encoding: 00 read, 01 write, 10 fetch. Kind 11 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 read) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | PA_W | Physical address, 0 on any fault |
| rsp_fault | output | 2 | 00 none, 01 invalid, 10 write to read-only, 11 fetch from no-execute |
| ld_en | input | 1 | Write one table entry |
| ld_page | input | log2(ENTRIES) | Entry to write |
| ld_frame | input | PA_W-log2(PAGE_BYTES) | Frame number to store |
| ld_present | input | 1 | Present bit to store |
| ld_writable | input | 1 | Writable bit to store |
| ld_noexec | input | 1 | No-execute bit to store |

## Verification
The handshake assertions assume that the consumer and the producer follow the valid/ready rules. That means `rsp_ready` may fall at any time, but a stalled response must not be dropped. The fault-path assertions assume that the table is only changed through the load port. The stimulus follows both assumptions. It drives every input half a cycle away from the active edge. Page numbers are drawn partly beyond the table depth. Random loads are interleaved with requests. Directed cases cover a stall of several cycles and a load to the same entry in the same cycle as a request.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_INVALID = 2'b01,
      FLT_WPROT   = 2'b10,
      FLT_NOEXEC  = 2'b11
   } flt_e;
endpackage

// File: rtl/pgxl_table.sv
module pgxl_table #(
   parameter int ENTRIES = 16,
   parameter int PFN_W   = 12,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [PFN_W-1:0] ld_pfn,
   input  logic             ld_present,
   input  logic             ld_wr,
   input  logic             ld_nx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PFN_W-1:0] rd_pfn,
   output logic             rd_present,
   output logic             rd_wr,
   output logic             rd_nx
);
   logic [PFN_W-1:0] pfn_q  [ENTRIES];
   logic             pres_q [ENTRIES];
   logic             wr_q   [ENTRIES];
   logic             nx_q   [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic hit;
      assign hit = ld_en && (ld_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pfn_q[e]  <= '0;
            pres_q[e] <= 1'b0;
            wr_q[e]   <= 1'b0;
            nx_q[e]   <= 1'b0;
         end else if (hit) begin
            pfn_q[e]  <= ld_pfn;
            pres_q[e] <= ld_present;
            wr_q[e]   <= ld_wr;
            nx_q[e]   <= ld_nx;
         end
      end
   end

   always_comb begin
      rd_pfn     = pfn_q[rd_idx];
      rd_present = pres_q[rd_idx];
      rd_wr      = wr_q[rd_idx];
      rd_nx      = nx_q[rd_idx];
   end

   // R10: a load lands in the addressed entry at the following edge
   p_load_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && rd_idx == ld_idx && $past(rst_n)) |=> (rd_idx != $past(ld_idx)) ||
      (rd_pfn == $past(ld_pfn) && rd_present == $past(ld_present)));
endmodule

// File: rtl/pgxl_check.sv
module pgxl_check
   import pgxl_pkg::*;
#(
   parameter int VPN_W = 8,
   parameter int IDX_W = 4,
   parameter int PFN_W = 12,
   parameter int OFF_W = 12,
   localparam int PA_W = PFN_W + OFF_W
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       kind,
   input  logic [PFN_W-1:0] ent_pfn,
   input  logic             ent_present,
   input  logic             ent_wr,
   input  logic             ent_nx,
   output logic [1:0]       fault,
   output logic [PA_W-1:0]  pa
);
   logic in_range;

   if (VPN_W > IDX_W) begin : g_range_chk
      assign in_range = (vpn[VPN_W-1:IDX_W] == '0);
   end else begin : g_range_full
      assign in_range = 1'b1;
   end

   flt_e f;
   always_comb begin
      if (!in_range || !ent_present)                 f = FLT_INVALID;
      else if (kind == ACC_WRITE && !ent_wr)         f = FLT_WPROT;
      else if (kind == ACC_FETCH && ent_nx)          f = FLT_NOEXEC;
      else                                           f = FLT_NONE;
   end

   assign fault = f;
   assign pa    = (f == FLT_NONE) ? {ent_pfn, off} : '0;

   // R4/R7: an absent or out-of-range page never yields any other code
   always_comb begin
      if (!in_range || !ent_present)
         p_invalid_first_r7: assert (fault == 2'b01);
   end
endmodule

// File: rtl/pgxl_rsp_reg.sv
module pgxl_rsp_reg #(
   parameter int PA_W = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [PA_W-1:0] pa_d,
   input  logic [1:0]      fault_d,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [PA_W-1:0] pa_q,
   output logic [1:0]      fault_q
);
   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pa_q      <= '0;
         fault_q   <= 2'b00;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) begin
            pa_q    <= pa_d;
            fault_q <= fault_d;
         end
      end
   end

   // R9: a stalled response is held
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(pa_q) && $stable(fault_q)));
endmodule

// File: rtl/pgxl_translator.sv
module pgxl_translator
   import pgxl_pkg::*;
#(
   parameter int VA_W       = 20,
   parameter int PA_W       = 24,
   parameter int PAGE_BYTES = 4096,
   parameter int ENTRIES    = 16,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int VPN_W     = VA_W - OFF_W,
   localparam int PFN_W     = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic [1:0]       req_kind,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_pa,
   output logic [1:0]       rsp_fault,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_page,
   input  logic [PFN_W-1:0] ld_frame,
   input  logic             ld_present,
   input  logic             ld_writable,
   input  logic             ld_noexec
);
   if (PAGE_BYTES < 512 || PAGE_BYTES > 8192 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("page size must be a power of two in 512..8192");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("table depth must be a power of two");
   end
   if (VPN_W < IDX_W || PFN_W < 1) begin : g_bad_width
      $error("address widths too narrow for page size and depth");
   end

   logic [VPN_W-1:0] vpn;
   logic [OFF_W-1:0] off;
   assign vpn = req_va[VA_W-1:OFF_W];
   assign off = req_va[OFF_W-1:0];

   logic [PFN_W-1:0] e_pfn;
   logic             e_pres, e_wr, e_nx;

   pgxl_table #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_idx(ld_page), .ld_pfn(ld_frame),
      .ld_present(ld_present), .ld_wr(ld_writable), .ld_nx(ld_noexec),
      .rd_idx(vpn[IDX_W-1:0]),
      .rd_pfn(e_pfn), .rd_present(e_pres), .rd_wr(e_wr), .rd_nx(e_nx)
   );

   logic [1:0]      c_fault;
   logic [PA_W-1:0] c_pa;

   pgxl_check #(.VPN_W(VPN_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_check (
      .vpn(vpn), .off(off), .kind(req_kind),
      .ent_pfn(e_pfn), .ent_present(e_pres), .ent_wr(e_wr), .ent_nx(e_nx),
      .fault(c_fault), .pa(c_pa)
   );

   pgxl_rsp_reg #(.PA_W(PA_W)) u_rsp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_ready(req_ready),
      .pa_d(c_pa), .fault_d(c_fault),
      .out_valid(rsp_valid), .out_ready(rsp_ready),
      .pa_q(rsp_pa), .fault_q(rsp_fault)
   );

   // R8: one cycle from acceptance to response
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R9: no acceptance while a response is stalled
   p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);

   // R4: a faulting response carries a zero address
   p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'b00) |-> (rsp_pa == '0));

   // R4: page numbers beyond the table always come back invalid
   p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (int'(vpn) >= ENTRIES)) |=> (rsp_fault == 2'b01));

   // R2: the offset is carried through unchanged on success
   p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
      (rsp_fault != 2'b00 || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));
endmodule

// File: tb/pgxl_translator_tb.sv
module pgxl_translator_tb_top;
   localparam int VA_W = 20, PA_W = 24, OFF_W = 12, PFN_W = 12, ENT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             req_valid = 0, rsp_ready = 1;
   logic [VA_W-1:0]  req_va = '0;
   logic [1:0]       req_kind = 2'b00;
   logic             req_ready, rsp_valid;
   logic [PA_W-1:0]  rsp_pa;
   logic [1:0]       rsp_fault;
   logic             ld_en = 0, ld_present = 0, ld_writable = 0, ld_noexec = 0;
   logic [3:0]       ld_page = '0;
   logic [PFN_W-1:0] ld_frame = '0;

   pgxl_translator dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_kind(req_kind),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .ld_en(ld_en), .ld_page(ld_page), .ld_frame(ld_frame),
      .ld_present(ld_present), .ld_writable(ld_writable), .ld_noexec(ld_noexec)
   );

   int total = 0, bad = 0;
   logic [PFN_W-1:0] m_pfn [ENT];
   logic             m_pres [ENT], m_wr [ENT], m_nx [ENT];

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // {fault, pa} from the requirements
   function automatic logic [25:0] expect_fn(input logic [VA_W-1:0] va, input logic [1:0] kind);
      int v = int'(va[VA_W-1:OFF_W]);
      if (v >= ENT || !m_pres[v])               return {2'b01, 24'h0};
      if (kind == 2'b01 && !m_wr[v])            return {2'b10, 24'h0};
      if (kind == 2'b10 && m_nx[v])             return {2'b11, 24'h0};
      return {2'b00, m_pfn[v], va[OFF_W-1:0]};
   endfunction

   task automatic load(input int pg, input logic [PFN_W-1:0] f, input logic p, w, x);
      @(negedge clk);
      ld_en = 1; ld_page = 4'(pg); ld_frame = f; ld_present = p; ld_writable = w; ld_noexec = x;
      @(negedge clk);
      ld_en = 0;
      m_pfn[pg] = f; m_pres[pg] = p; m_wr[pg] = w; m_nx[pg] = x;
   endtask

   task automatic run_req(input logic [VA_W-1:0] va, input logic [1:0] kind, input string tag);
      logic [25:0] e;
      e = expect_fn(va, kind);
      @(negedge clk);
      rsp_ready = 1; req_valid = 1; req_va = va; req_kind = kind;
      @(negedge clk);
      req_valid = 0;
      check({tag, " R8 valid"}, 32'(rsp_valid), 32'd1);
      check(tag, 32'({rsp_fault, rsp_pa}), 32'(e));
   endtask

   initial begin
      #(8 * 100000);
      bad++; total++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      for (int i = 0; i < ENT; i++) begin
         m_pfn[i] = '0; m_pres[i] = 0; m_wr[i] = 0; m_nx[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 rsp_valid after reset", 32'(rsp_valid), 0);
      check("R1 req_ready after reset", 32'(req_ready), 1);
      run_req(20'h03_456, 2'b00, "R1 empty table invalid");

      // directed pages: 1 rw, 2 read-only, 3 no-exec rw, 4 no-exec read-only
      load(1, 12'hABC, 1, 1, 0);
      load(2, 12'h123, 1, 0, 0);
      load(3, 12'hF0F, 1, 1, 1);
      load(4, 12'h777, 1, 0, 1);
      run_req(20'h01_FFF, 2'b00, "R2 R3 read ok");
      run_req(20'h01_000, 2'b10, "R3 fetch ok");
      run_req(20'h02_5A5, 2'b01, "R5 write read-only");
      run_req(20'h02_5A5, 2'b00, "R3 read read-only");
      run_req(20'h03_010, 2'b10, "R6 fetch noexec");
      run_req(20'h03_010, 2'b01, "R6 write noexec ok");
      run_req(20'h04_0F0, 2'b01, "R5 write ro+nx");
      run_req(20'h04_0F0, 2'b11, "R11 kind 11 as read");
      run_req(20'h10_123, 2'b00, "R4 page beyond depth");
      run_req(20'hFF_FFF, 2'b10, "R4 top page");
      load(5, 12'h555, 0, 0, 1);
      run_req(20'h05_001, 2'b10, "R7 invalid over noexec");
      run_req(20'h05_001, 2'b01, "R7 invalid over wprot");

      // R10 same-edge load and request
      @(negedge clk);
      rsp_ready = 1; req_valid = 1; req_va = 20'h02_044; req_kind = 2'b01;
      ld_en = 1; ld_page = 4'd2; ld_frame = 12'h999; ld_present = 1; ld_writable = 1; ld_noexec = 0;
      @(negedge clk);
      begin
         logic [25:0] e_old;
         e_old = expect_fn(20'h02_044, 2'b01);
         req_valid = 0; ld_en = 0;
         check("R10 sees old entry", 32'({rsp_fault, rsp_pa}), 32'(e_old));
      end
      m_pfn[2] = 12'h999; m_pres[2] = 1; m_wr[2] = 1; m_nx[2] = 0;
      run_req(20'h02_044, 2'b01, "R10 sees new entry");

      // R9 stall
      @(negedge clk);
      rsp_ready = 0; req_valid = 1; req_va = 20'h01_234; req_kind = 2'b00;
      @(negedge clk);
      req_va = 20'h03_321; req_kind = 2'b10;
      for (int k = 0; k < 3; k++) begin
         check("R9 held valid", 32'(rsp_valid), 1);
         check("R9 ready low", 32'(req_ready), 0);
         check("R9 held data", 32'({rsp_fault, rsp_pa}), 32'(expect_fn(20'h01_234, 2'b00)));
         @(negedge clk);
      end
      rsp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      check("R9 next after stall", 32'({rsp_fault, rsp_pa}), 32'(expect_fn(20'h03_321, 2'b10)));

      // random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 4 == 0)
            load(int'($urandom % ENT), 12'($urandom), 1'($urandom % 4 != 0),
                 1'($urandom), 1'($urandom));
         run_req({8'($urandom % 24), 12'($urandom)}, 2'($urandom), "R2 R3 R4 R5 R6 random");
      end

      @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule